// File: doc/BRIEF.md
# Prioritised Interrupt Request Controller

This block collects interrupt requests from fourteen fixed peripheral sources and presents a single 3-bit priority level to a CPU. It holds two 15-bit registers: a pending-request register and an enable mask. Bit 14 of the enable mask acts as a master enable. Each hardware source raises its own request bit with a one-cycle pulse. That bit stays pending until software clears it.

Software reaches both registers through a small register bus. The bus has one address for reading and a separate address for writing each register. Writes do not load data directly. Bit 15 of the written word chooses between setting and clearing. Every register bit that matches a 1 in the lower fifteen data bits is set or cleared, and all other bits keep their value. The fourteen sources fall into six priority groups, and more than one source can share a group. The output carries the number of the highest group that has a request both pending and enabled. The block never produces level 7. It does not supply vectors, does not take part in CPU acknowledge cycles, and does not contain the peripherals.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, both registers read as zero and the level output is 0.
- R2: Reading word address 0x1C returns the enable mask and reading 0x1E returns the pending requests, in bits 14:0. Bit 15 always reads 0, and any other read address returns 0.
- R3: A write to 0x9A (enable) or 0x9C (request) with data bit 15 = 1 sets each register bit whose data bit is 1. With data bit 15 = 0 it clears those bits instead. Bits whose data bit is 0 do not change, so writing 0x0020 to 0x9C clears only bit 5.
- R4: A pulse on source input k (0 to 13) sets request bit k whatever the enable mask holds. The bit then stays set while the input is low, until software clears it.
- R5: When a source pulse and a software clear hit the same request bit in the same cycle, the bit ends up set.
- R6: The source bits map onto levels as follows. Level 1 takes bits 0, 1 and 2. Level 2 takes bit 3. Level 3 takes bits 4, 5 and 6. Level 4 takes bits 7 to 10. Level 5 takes bits 11 and 12. Level 6 takes bit 13.
- R7: The output is the highest level that has at least one bit both pending and enabled. It is 0 when no such bit exists.
- R8: While enable bit 14 (the master enable) is 0, the level output is 0 whatever the other bits hold.
- R9: The level output never takes the value 7.
- R10: The level output is registered. It changes on the same clock edge that updates the registers after a write or a source pulse, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 9 | Word write address |
| wr_data | input | 16 | Write data; bit 15 selects set or clear |
| rd_addr | input | 9 | Word read address |
| rd_data | output | 16 | Read data for rd_addr |
| src_pulse | input | 14 | One-cycle request pulses from the sources |
| ipl | output | 3 | Registered priority level to the CPU |

## Verification
A corrupted pending or enable bit shows up at two places. It appears on the read port as soon as the register is read back. It also appears on the level output at the clock edge that stores the bad value, because the output is computed from the next-state values and is therefore never one edge behind the registers. A wrong group mapping, or a wrong order among the groups, only becomes visible when exactly that source is the highest enabled request. For that reason each source is pulsed on its own, and groups are then removed one at a time, from the top level down.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int NUM_SRC  = 14;
    localparam int REG_W    = NUM_SRC + 1;
    localparam int MASTER   = NUM_SRC;
    localparam int ADDR_W   = 9;
    localparam int DATA_W   = 16;
    localparam int LVL_W    = 3;
    localparam int TOP_LVL  = 6;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [LVL_W-1:0]  lvl_t;

    localparam addr_t ENA_RD = 9'h01C;
    localparam addr_t REQ_RD = 9'h01E;
    localparam addr_t ENA_WR = 9'h09A;
    localparam addr_t REQ_WR = 9'h09C;

    typedef struct packed {
        logic             set_op;
        logic [REG_W-1:0] bits;
    } sc_word_t;

    // Priority group of one source bit.
    function automatic lvl_t src_level(input int idx);
        if (idx <= 2)       return 3'd1;
        else if (idx == 3)  return 3'd2;
        else if (idx <= 6)  return 3'd3;
        else if (idx <= 10) return 3'd4;
        else if (idx <= 12) return 3'd5;
        else                return 3'd6;
    endfunction

    // Bits belonging to group lvl.
    function automatic logic [NUM_SRC-1:0] level_mask(input int lvl);
        logic [NUM_SRC-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_SRC; i++)
            if (int'(src_level(i)) == lvl) m[i] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/irq_sc_reg.sv
module irq_sc_reg
    import irq_prio_pkg::*;
#(
    parameter int    W       = REG_W,
    parameter addr_t WR_ADDR = ENA_WR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  addr_t             wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [W-1:0]      hw_set,
    output logic [W-1:0]      q,
    output logic [W-1:0]      d
);

    sc_word_t        cmd;
    logic            hit;
    logic [W-1:0]    sw_set;
    logic [W-1:0]    sw_clr;

    always_comb begin
        cmd    = sc_word_t'(wr_data);
        hit    = wr_en && (wr_addr == WR_ADDR);
        sw_set = (hit &&  cmd.set_op) ? cmd.bits[W-1:0] : '0;
        sw_clr = (hit && !cmd.set_op) ? cmd.bits[W-1:0] : '0;
        // hardware set is applied last so it wins over a clear
        d      = (q & ~sw_clr) | sw_set | hw_set;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

endmodule

// File: rtl/irq_level_enc.sv
module irq_level_enc
    import irq_prio_pkg::*;
(
    input  logic [NUM_SRC-1:0] active,
    output lvl_t               lvl
);

    logic [TOP_LVL:0] grp;

    assign grp[0] = 1'b0;

    generate
        for (genvar l = 1; l <= TOP_LVL; l++) begin : g_grp
            localparam logic [NUM_SRC-1:0] MASK = level_mask(l);
            assign grp[l] = |(active & MASK);
        end
    endgenerate

    always_comb begin
        lvl = '0;
        for (int l = 1; l <= TOP_LVL; l++)
            if (grp[l]) lvl = lvl_t'(l);
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [NUM_SRC-1:0] src_pulse,
    output logic [LVL_W-1:0]  ipl
);

    logic [REG_W-1:0]   ena_q, ena_d;
    logic [REG_W-1:0]   req_q, req_d;
    logic [NUM_SRC-1:0] active;
    lvl_t               lvl_next;

    irq_sc_reg #(.W(REG_W), .WR_ADDR(ENA_WR)) u_ena (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .hw_set('0), .q(ena_q), .d(ena_d)
    );

    irq_sc_reg #(.W(REG_W), .WR_ADDR(REQ_WR)) u_req (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .hw_set({1'b0, src_pulse}), .q(req_q), .d(req_d)
    );

    // next-state values feed the encoder so ipl moves with the registers
    assign active = req_d[NUM_SRC-1:0] & ena_d[NUM_SRC-1:0] & {NUM_SRC{ena_d[MASTER]}};

    irq_level_enc u_enc (.active(active), .lvl(lvl_next));

    always_ff @(posedge clk) begin
        if (rst) ipl <= '0;
        else     ipl <= lvl_next;
    end

    always_comb begin
        unique case (rd_addr)
            ENA_RD:  rd_data = {1'b0, ena_q};
            REQ_RD:  rd_data = {1'b0, req_q};
            default: rd_data = '0;
        endcase
    end

    // R9
    p_no_level7_r9: assert property (@(posedge clk) disable iff (rst)
        ipl != 3'd7);

    // R8
    p_master_gate_r8: assert property (@(posedge clk) disable iff (rst)
        !ena_q[MASTER] |-> ipl == '0);

    // R7
    p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst)
        ((req_q[NUM_SRC-1:0] & ena_q[NUM_SRC-1:0]) == '0) |-> ipl == '0);

    // R4
    p_hw_sets_r4: assert property (@(posedge clk) disable iff (rst)
        (|src_pulse) |=> ((req_q[NUM_SRC-1:0] & $past(src_pulse)) == $past(src_pulse)));

    // R3
    p_sw_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == REQ_WR && !wr_data[15] && src_pulse == '0)
        |=> ((req_q & $past(wr_data[REG_W-1:0])) == '0));

    // R2
    p_read_msb_r2: assert property (@(posedge clk) disable iff (rst)
        rd_data[15] == 1'b0);

endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [8:0]  wr_addr;
    logic [15:0] wr_data;
    logic [8:0]  rd_addr;
    logic [15:0] rd_data;
    logic [13:0] src_pulse;
    logic [2:0]  ipl;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_prio_ctrl u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .src_pulse(src_pulse), .ipl(ipl)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] lvl_of(input int b);
        case (b)
            0, 1, 2:      return 3'd1;
            3:            return 3'd2;
            4, 5, 6:      return 3'd3;
            7, 8, 9, 10:  return 3'd4;
            11, 12:       return 3'd5;
            default:      return 3'd6;
        endcase
    endfunction

    task automatic wr(input logic [8:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [13:0] p);
        @(negedge clk);
        src_pulse = p;
        @(negedge clk);
        src_pulse = '0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [15:0] d);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic wipe();
        wr(9'h09A, 16'h7FFF);
        wr(9'h09C, 16'h7FFF);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0; src_pulse = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        rd(9'h01C, v); chk("R1 enable after reset", v, 16'h0000);
        rd(9'h01E, v); chk("R1 request after reset", v, 16'h0000);
        chk("R1 ipl after reset", {13'd0, ipl}, 16'h0000);
    endtask

    task automatic t_setclr();
        logic [15:0] v;
        wr(9'h09A, 16'h8421); rd(9'h01C, v); chk("R3 enable set", v, 16'h0421);
        wr(9'h09A, 16'h8010); rd(9'h01C, v); chk("R3 enable set keeps others", v, 16'h0431);
        wr(9'h09A, 16'h0401); rd(9'h01C, v); chk("R3 enable clear", v, 16'h0030);
        wr(9'h09C, 16'hFFFF); rd(9'h01E, v); chk("R2 request bit15 reads 0", v, 16'h7FFF);
        wr(9'h09C, 16'h0020); rd(9'h01E, v); chk("R3 0x0020 clears vblank only", v, 16'h7FDF);
        rd(9'h0AA, v); chk("R2 unmapped read", v, 16'h0000);
        rd(9'h09C, v); chk("R2 write address not readable", v, 16'h0000);
        wipe();
        rd(9'h01C, v); chk("R3 enable cleared", v, 16'h0000);
    endtask

    task automatic t_hw_pulse();
        logic [15:0] v;
        wipe();
        pulse(14'h2081);
        rd(9'h01E, v); chk("R4 pulses set with mask off", v, 16'h2081);
        repeat (3) @(negedge clk);
        rd(9'h01E, v); chk("R4 requests hold", v, 16'h2081);
        chk("R8 no level without master", {13'd0, ipl}, 16'h0000);
    endtask

    task automatic t_collision();
        logic [15:0] v;
        wipe();
        wr(9'h09C, 16'h8804);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 9'h09C; wr_data = 16'h0804; src_pulse = 14'h0004;
        @(negedge clk);
        wr_en = 1'b0; src_pulse = '0;
        rd(9'h01E, v); chk("R5 set beats clear", v, 16'h0004);
    endtask

    task automatic t_levels();
        for (int b = 0; b < 14; b++) begin
            wipe();
            wr(9'h09A, 16'hC000 | (16'h1 << b));
            chk("R6 idle before pulse", {13'd0, ipl}, 16'h0000);
            pulse(14'h1 << b);
            chk($sformatf("R6 source %0d level", b), {13'd0, ipl}, {13'd0, lvl_of(b)});
        end
    endtask

    task automatic t_priority();
        wipe();
        wr(9'h09A, 16'hFFFF);
        pulse(14'h0089);
        chk("R7 highest of 1,2,4", {13'd0, ipl}, 16'd4);
        wr(9'h09C, 16'h0080);
        chk("R7 after audio clear", {13'd0, ipl}, 16'd2);
        wr(9'h09A, 16'h0008);
        chk("R7 disabled pending ignored", {13'd0, ipl}, 16'd1);
        wr(9'h09A, 16'h8008);
        pulse(14'h3FFF);
        chk("R9 all active gives 6", {13'd0, ipl}, 16'd6);
        wr(9'h09A, 16'h4000);
        chk("R8 master off", {13'd0, ipl}, 16'd0);
        wr(9'h09A, 16'hC000);
        chk("R8 master on", {13'd0, ipl}, 16'd6);
        wr(9'h09C, 16'h3FFF);
        chk("R7 none pending", {13'd0, ipl}, 16'd0);
    endtask

    task automatic t_latency();
        wipe();
        wr(9'h09A, 16'hC800);
        @(negedge clk);
        src_pulse = 14'h0800;
        #1 chk("R10 no change before edge", {13'd0, ipl}, 16'd0);
        @(posedge clk);
        #1 src_pulse = '0;
        chk("R10 change at edge", {13'd0, ipl}, 16'd5);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_setclr();
        t_hw_pulse();
        t_collision();
        t_levels();
        t_priority();
        t_latency();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule